// File: doc/BRIEF.md
# UART Interrupt Enable and Prioritisation Logic

This block belongs to one UART channel. It holds the channel's 8-bit interrupt enable register and combines that register with the raw interrupt sources to produce one interrupt request. The sources are receiver status, receive data ready, transmitter empty, modem status, special-character match, RTS change and CTS change. Each source arrives as a level pending flag that other logic owns and clears. The block gates every flag with its enable bit, picks the most urgent enabled source, reports it as a level code, and drives one interrupt line towards the host interrupt controller. That line is not gated by any modem-control output bit.

Three controls change what the enable bits mean. With 9-bit framing on, a received character that has its address bit set counts as a receiver-status cause. With enhanced mode off, the RTS and CTS interrupts are always enabled. In the 750-style compatibility mode without 9-bit framing, bit 5 stops enabling an interrupt and drives a sleep request output instead. The block does no clock gating itself.

Top module: `uart_irq_enable`

## Requirements
- R1: A synchronous active-high reset clears the enable register to 0x00, so no source can raise the interrupt after reset until software writes the register.
- R2: A write (`wr_en` high at a clock edge) stores `wr_data` into the register. Bit 4 is reserved: it always reads back as 0 on `ier_q` and enables nothing.
- R3: Register bit 0 enables receive data ready (level 2), bit 1 enables transmitter empty (level 3), bit 2 enables receiver status (level 1), and bit 3 enables modem status (level 4).
- R4: When `nine_bit_en` is 1 and bit 2 is set, a pending address-bit flag raises level 1. When `nine_bit_en` is 0, the address-bit flag has no effect.
- R5: When bit 5 is set and a special-character match is pending, level 5 is raised, except in the case that R7 describes.
- R6: When `enh_en` is 1, bit 6 enables the RTS interrupt and bit 7 enables the CTS interrupt, both at level 6. When `enh_en` is 0, both are enabled whatever bits 6 and 7 hold.
- R7: When `compat_mode` is 2'b10 and `nine_bit_en` is 0, bit 5 drives `sleep_req` and the special-character source never raises an interrupt. In every other mode, `sleep_req` is 0.
- R8: When several enabled sources are pending, `irq_level` reports the lowest level number (level 1 first, level 6 last). `irq_level` is 0 when no enabled source is pending.
- R9: `irq_out` is 1 exactly when `irq_level` is non-zero. No modem-control bit takes part.
- R10: Clearing an enable bit removes its source from `irq_level` and `irq_out` in the cycle after the write, even while the pending flag stays high. Setting the bit again brings the source back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the enable register |
| wr_data | input | 8 | Value to store in the enable register |
| nine_bit_en | input | 1 | 9-bit framing enabled |
| enh_en | input | 1 | Enhanced mode enabled |
| compat_mode | input | 2 | Compatibility mode select; 2'b10 is the 750-style mode |
| ev_rx_status | input | 1 | Receiver status error pending |
| ev_addr_bit | input | 1 | Character with address bit set received |
| ev_rx_data | input | 1 | Receive data ready pending |
| ev_tx_empty | input | 1 | Transmitter empty pending |
| ev_modem | input | 1 | Modem status change pending |
| ev_special | input | 1 | Special-character match pending |
| ev_rts | input | 1 | RTS change pending |
| ev_cts | input | 1 | CTS change pending |
| ier_q | output | 8 | Current enable register value, bit 4 always 0 |
| irq_level | output | 3 | Active interrupt level code, 0 when none |
| irq_out | output | 1 | Interrupt request to the host |
| sleep_req | output | 1 | Alternative sleep request |

## Verification
The assertions check, on every cycle, these properties: register capture with the reserved bit forced low, the reserved bit reading zero, level 1 winning whenever its gated request is present, the line agreeing with the level code, forced RTS/CTS enabling outside enhanced mode, and the absence of level 5 in the 750-style sleep mode. The bench's scenarios show the mode-dependent meaning of each bit. They check that the address bit is ignored without 9-bit framing, that the full priority order holds as sources drop out one by one, and that a cleared enable masks its source on the following cycle while the flag is still pending. A behavioural reference model is compared against every output on every clock.

// File: rtl/uie_pkg.sv
package uie_pkg;

   localparam int unsigned IER_W   = 8;
   localparam int unsigned NUM_SRC = 6;
   localparam int unsigned LVL_W   = $clog2(NUM_SRC + 1);

   // enable register bit positions
   localparam int unsigned B_RXD  = 0;
   localparam int unsigned B_TXE  = 1;
   localparam int unsigned B_RXS  = 2;
   localparam int unsigned B_MDM  = 3;
   localparam int unsigned B_RSV  = 4;
   localparam int unsigned B_SPC  = 5;
   localparam int unsigned B_RTS  = 6;
   localparam int unsigned B_CTS  = 7;

   // request vector index = level - 1
   typedef enum logic [LVL_W-1:0] {
      LVL_NONE  = 3'd0,
      LVL_RXS   = 3'd1,
      LVL_RXD   = 3'd2,
      LVL_TXE   = 3'd3,
      LVL_MDM   = 3'd4,
      LVL_SPC   = 3'd5,
      LVL_FLOW  = 3'd6
   } uie_level_e;

   typedef struct packed {
      logic rx_status;
      logic addr_bit;
      logic rx_data;
      logic tx_empty;
      logic modem;
      logic special;
      logic rts;
      logic cts;
   } uie_events_t;

endpackage

// File: rtl/uie_enable_reg.sv
module uie_enable_reg #(
   parameter int unsigned           W         = 8,
   parameter logic [W-1:0]          RESET_VAL = '0,
   parameter logic [W-1:0]          RSV_MASK  = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] q
);

   if ((RESET_VAL & RSV_MASK) != '0) begin : g_bad_reset
      $error("uie_enable_reg: reset value sets a reserved bit");
   end

   logic [W-1:0] q_r;

   always_ff @(posedge clk) begin
      if (rst)
         q_r <= RESET_VAL;
      else if (wr_en)
         q_r <= wr_data & ~RSV_MASK;
   end

   assign q = q_r;

   AST_WR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (q == ($past(wr_data) & ~RSV_MASK)));               // R2
   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
      (q & RSV_MASK) == '0);                                        // R2
   AST_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(q));                                       // R10

endmodule

// File: rtl/uie_gate.sv
module uie_gate
   import uie_pkg::*;
#(
   parameter int unsigned  MODE_W     = 2,
   parameter logic [MODE_W-1:0] SLEEP_MODE = 2'b10
) (
   input  logic [IER_W-1:0]   ier,
   input  uie_events_t        ev,
   input  logic               nine_bit_en,
   input  logic               enh_en,
   input  logic [MODE_W-1:0]  compat_mode,
   output logic [NUM_SRC-1:0] req,
   output logic               sleep_req
);

   if (MODE_W < 1) begin : g_bad_mode
      $error("uie_gate: MODE_W must be at least 1");
   end

   logic sleep_mode;
   logic rts_en;
   logic cts_en;
   logic rxs_cause;

   assign sleep_mode = (compat_mode == SLEEP_MODE) && !nine_bit_en;
   assign rts_en     = enh_en ? ier[B_RTS] : 1'b1;
   assign cts_en     = enh_en ? ier[B_CTS] : 1'b1;
   assign rxs_cause  = ev.rx_status | (nine_bit_en & ev.addr_bit);

   always_comb begin
      req                      = '0;
      req[LVL_RXS - 1]  = ier[B_RXS] & rxs_cause;
      req[LVL_RXD - 1]  = ier[B_RXD] & ev.rx_data;
      req[LVL_TXE - 1]  = ier[B_TXE] & ev.tx_empty;
      req[LVL_MDM - 1]  = ier[B_MDM] & ev.modem;
      req[LVL_SPC - 1]  = ier[B_SPC] & ev.special & !sleep_mode;
      req[LVL_FLOW - 1] = (rts_en & ev.rts) | (cts_en & ev.cts);
   end

   assign sleep_req = sleep_mode & ier[B_SPC];

endmodule

// File: rtl/uie_prio_enc.sv
module uie_prio_enc #(
   parameter int unsigned N       = 6,
   parameter bit          REG_OUT = 1'b0,
   localparam int unsigned CW     = $clog2(N + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [N-1:0]  req,
   output logic [CW-1:0] code,
   output logic          any
);

   if (N < 2) begin : g_bad_n
      $error("uie_prio_enc: need at least two sources");
   end

   logic [CW-1:0] code_c;

   // lowest index wins: scan from the top so the lowest overwrites last
   always_comb begin
      code_c = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) code_c = CW'(i + 1);
      end
   end

   if (REG_OUT) begin : g_reg
      logic [CW-1:0] code_r;
      always_ff @(posedge clk) begin
         if (rst) code_r <= '0;
         else     code_r <= code_c;
      end
      assign code = code_r;
   end else begin : g_comb
      assign code = code_c;
   end

   assign any = (code != '0);

   AST_TOP_WINS: assert property (@(posedge clk) disable iff (rst)
      req[0] |-> (code_c == CW'(1)));                               // R8
   AST_NONE_IDLE: assert property (@(posedge clk) disable iff (rst)
      (req == '0) |-> (code_c == '0));                              // R8
   AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
      code_c <= CW'(N));                                            // R8

endmodule

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
   import uie_pkg::*;
#(
   parameter logic [7:0] RESET_VAL  = 8'h00,
   parameter logic [1:0] SLEEP_MODE = 2'b10,
   parameter bit         REG_OUT    = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       nine_bit_en,
   input  logic       enh_en,
   input  logic [1:0] compat_mode,
   input  logic       ev_rx_status,
   input  logic       ev_addr_bit,
   input  logic       ev_rx_data,
   input  logic       ev_tx_empty,
   input  logic       ev_modem,
   input  logic       ev_special,
   input  logic       ev_rts,
   input  logic       ev_cts,
   output logic [7:0] ier_q,
   output logic [2:0] irq_level,
   output logic       irq_out,
   output logic       sleep_req
);

   localparam logic [IER_W-1:0] RSV_MASK = IER_W'(1) << B_RSV;

   if (LVL_W != 3) begin : g_bad_lvl
      $error("uart_irq_enable: level code must be 3 bits wide");
   end

   uie_events_t        ev;
   logic [IER_W-1:0]   ier;
   logic [NUM_SRC-1:0] req;

   assign ev = '{rx_status: ev_rx_status, addr_bit: ev_addr_bit,
                 rx_data: ev_rx_data, tx_empty: ev_tx_empty,
                 modem: ev_modem, special: ev_special,
                 rts: ev_rts, cts: ev_cts};

   uie_enable_reg #(
      .W         (IER_W),
      .RESET_VAL (RESET_VAL),
      .RSV_MASK  (RSV_MASK)
   ) u_reg (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .q       (ier)
   );

   uie_gate #(
      .MODE_W     (2),
      .SLEEP_MODE (SLEEP_MODE)
   ) u_gate (
      .ier         (ier),
      .ev          (ev),
      .nine_bit_en (nine_bit_en),
      .enh_en      (enh_en),
      .compat_mode (compat_mode),
      .req         (req),
      .sleep_req   (sleep_req)
   );

   uie_prio_enc #(
      .N       (NUM_SRC),
      .REG_OUT (REG_OUT)
   ) u_prio (
      .clk  (clk),
      .rst  (rst),
      .req  (req),
      .code (irq_level),
      .any  (irq_out)
   );

   assign ier_q = ier;

   AST_LINE_MATCH: assert property (@(posedge clk) disable iff (rst)
      irq_out == (irq_level != 3'd0));                              // R9
   AST_SLEEP_MODE_ONLY: assert property (@(posedge clk) disable iff (rst)
      sleep_req |-> (compat_mode == SLEEP_MODE && !nine_bit_en));   // R7

   if (!REG_OUT) begin : g_comb_checks
      AST_FLOW_FORCED: assert property (@(posedge clk) disable iff (rst)
         (!enh_en && (ev_rts || ev_cts)) |-> irq_out);              // R6
      AST_NO_SPC_IN_SLEEP: assert property (@(posedge clk) disable iff (rst)
         (compat_mode == SLEEP_MODE && !nine_bit_en) |-> (irq_level != 3'd5)); // R7
      AST_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
         (!nine_bit_en && ev_addr_bit && !ev_rx_status) |-> (irq_level != 3'd1)); // R4
   end

endmodule

// File: tb/sim_uart_irq_enable.sv
`timescale 1ns/1ps
module sim_uart_irq_enable;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic nb = 1'b0, enh = 1'b0;
   logic [1:0] mode = 2'b11;
   logic rxs = 0, addr = 0, rxd = 0, txe = 0, mdm = 0, spc = 0, rts = 0, cts = 0;
   logic [7:0] ier_q;
   logic [2:0] irq_level;
   logic irq_out, sleep_req;

   int tests = 0;
   int fails = 0;
   bit done = 0;
   logic [7:0] m_ier = 8'h00;

   always #5 clk = ~clk;

   uart_irq_enable u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .nine_bit_en(nb), .enh_en(enh), .compat_mode(mode),
      .ev_rx_status(rxs), .ev_addr_bit(addr), .ev_rx_data(rxd),
      .ev_tx_empty(txe), .ev_modem(mdm), .ev_special(spc),
      .ev_rts(rts), .ev_cts(cts),
      .ier_q(ier_q), .irq_level(irq_level), .irq_out(irq_out),
      .sleep_req(sleep_req));

   // reference register model (R1, R2)
   always @(posedge clk) begin
      if (rst)        m_ier <= 8'h00;
      else if (wr_en) m_ier <= wr_data & 8'hEF;
   end

   function automatic int exp_level();
      bit sl;
      sl = (mode == 2'b10) && !nb;
      if (m_ier[2] && (rxs || (nb && addr)))                  return 1;
      if (m_ier[0] && rxd)                                    return 2;
      if (m_ier[1] && txe)                                    return 3;
      if (m_ier[3] && mdm)                                    return 4;
      if (m_ier[5] && spc && !sl)                             return 5;
      if ((rts && (!enh || m_ier[6])) || (cts && (!enh || m_ier[7]))) return 6;
      return 0;
   endfunction

   task automatic chk(string tag, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (!rst && !done) begin
         chk("R2 ier_q model", ier_q, m_ier);
         chk("R8 irq_level model", irq_level, exp_level());
         chk("R9 irq_out model", irq_out, exp_level() != 0);
         chk("R7 sleep_req model", sleep_req, m_ier[5] && mode == 2'b10 && !nb);
      end
   end

   task automatic wr(logic [7:0] v);
      @(posedge clk); #2; wr_en = 1'b1; wr_data = v;
      @(posedge clk); #2; wr_en = 1'b0;
   endtask

   task automatic settle();
      @(posedge clk); #2;
      @(negedge clk);
   endtask

   task automatic clr_ev();
      {rxs, addr, rxd, txe, mdm, spc, rts, cts} = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         tests++; fails++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state, all sources pending, enhanced on
      enh = 1'b1;
      {rxs, rxd, txe, mdm, spc} = '1;
      repeat (3) @(posedge clk);
      #2 rst = 1'b0;
      @(negedge clk);
      chk("R1 ier_q after reset", ier_q, 8'h00);
      chk("R1 irq_level after reset", irq_level, 0);
      clr_ev();

      // R2: write all ones, bit 4 reads 0
      wr(8'hFF); @(negedge clk);
      chk("R2 reserved bit clear", ier_q, 8'hEF);
      wr(8'h10); @(negedge clk);
      chk("R2 only reserved written", ier_q, 8'h00);

      // R3: individual enables
      wr(8'h01); rxd = 1; settle();
      chk("R3 rx data level", irq_level, 2);
      clr_ev(); wr(8'h02); txe = 1; settle();
      chk("R3 tx empty level", irq_level, 3);
      clr_ev(); wr(8'h04); rxs = 1; settle();
      chk("R3 rx status level", irq_level, 1);
      clr_ev(); wr(8'h08); mdm = 1; settle();
      chk("R3 modem level", irq_level, 4);
      wr(8'h07); settle();
      chk("R3 modem masked", irq_level, 0);

      // R4: address bit
      clr_ev(); wr(8'h04); addr = 1; nb = 1; settle();
      chk("R4 address bit raises level 1", irq_level, 1);
      nb = 0; settle();
      chk("R4 address bit ignored without 9-bit", irq_level, 0);
      chk("R4 line low", irq_out, 0);

      // R5 / R7: special character and sleep request
      clr_ev(); wr(8'h20); spc = 1; mode = 2'b11; settle();
      chk("R5 special level", irq_level, 5);
      chk("R7 no sleep outside 750", sleep_req, 0);
      mode = 2'b10; settle();
      chk("R7 special masked in 750", irq_level, 0);
      chk("R7 sleep requested", sleep_req, 1);
      nb = 1; settle();
      chk("R5 special in 750 with 9-bit", irq_level, 5);
      chk("R7 no sleep with 9-bit", sleep_req, 0);
      nb = 0; mode = 2'b11;

      // R6: RTS / CTS
      clr_ev(); wr(8'h00); enh = 1; rts = 1; settle();
      chk("R6 rts masked in enhanced", irq_level, 0);
      wr(8'h40); settle();
      chk("R6 rts enabled by bit 6", irq_level, 6);
      rts = 0; cts = 1; settle();
      chk("R6 cts needs bit 7", irq_level, 0);
      wr(8'h80); settle();
      chk("R6 cts enabled by bit 7", irq_level, 6);
      wr(8'h00); enh = 0; settle();
      chk("R6 cts forced when not enhanced", irq_level, 6);
      cts = 0; rts = 1; settle();
      chk("R6 rts forced when not enhanced", irq_out, 1);

      // R8 / R9: priority order as sources drop out
      enh = 1; wr(8'hEF);
      {rxs, rxd, txe, mdm, spc, rts, cts} = '1; settle();
      chk("R8 all pending", irq_level, 1);
      rxs = 0; settle(); chk("R8 next rx data", irq_level, 2);
      rxd = 0; settle(); chk("R8 next tx empty", irq_level, 3);
      txe = 0; settle(); chk("R8 next modem", irq_level, 4);
      mdm = 0; settle(); chk("R8 next special", irq_level, 5);
      spc = 0; settle(); chk("R8 next flow", irq_level, 6);
      chk("R9 line high", irq_out, 1);
      rts = 0; cts = 0; settle();
      chk("R9 line low when idle", irq_out, 0);

      // R10: mask takes effect on the cycle after the write
      clr_ev(); wr(8'h01); rxd = 1; settle();
      chk("R10 source active", irq_level, 2);
      @(posedge clk); #2; wr_en = 1; wr_data = 8'h00;
      @(negedge clk);
      chk("R10 unchanged before edge", irq_level, 2);
      @(posedge clk); #2; wr_en = 0;
      @(negedge clk);
      chk("R10 masked after write", irq_level, 0);
      wr(8'h01); @(negedge clk);
      chk("R10 pending flag returns", irq_level, 2);

      // R1: synchronous reset mid-run
      @(posedge clk); #2 rst = 1;
      @(posedge clk); #2 rst = 0;
      @(negedge clk);
      chk("R1 reset clears register", ier_q, 8'h00);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule